// File: doc/BRIEF.md
# Condition Flag Register and Branch Evaluator

This block keeps the four processor status flags (negative, zero, overflow, carry) and turns a 4-bit branch condition field into a single taken/not-taken decision. The ALU result, carry-out and overflow come in alongside an operation class and a per-instruction flag-write enable. The flags change on the next rising clock edge, and only for the classes that are meant to touch them. A shift changes the carry alone. A logical operation changes negative and zero alone.

The branch decision is combinational on the registered flags. A branch issued in the same cycle as a flag-setting instruction therefore sees the flags as they were before that instruction. The surrounding pipeline has to account for this dependency. A decrement with flags enabled, followed by a branch-if-positive one cycle later, closes a loop without a separate compare.

Top module: `cc_flag_unit`

## Requirements
- R1: While rst_ni is low, flags_o (bit 3 N, bit 2 Z, bit 1 V, bit 0 C) is 4'b0000.
- R2: With flag_we_i high and op_cls_i = 0 (add/subtract), the next edge loads N = res_i MSB, Z = (res_i == 0), V = ovf_i, C = carry_i.
- R3: With flag_we_i high and op_cls_i = 4 (compare), all four flags load exactly as in R2.
- R4: With flag_we_i high and op_cls_i = 1 (logical), N and Z load as in R2, while V and C keep their values.
- R5: With flag_we_i high and op_cls_i = 2 (shift), only C loads from carry_i, while N, Z and V keep their values.
- R6: With op_cls_i = 3 (move) or any class code 5 to 7, the flags keep their values even when flag_we_i is high.
- R7: With flag_we_i low, the flags keep their values whatever the other inputs are.
- R8: Codes 0 to 7 on cond_i mean: 0 always, 1 never, 2 not-equal (~Z), 3 equal (Z), 4 signed greater, 5 signed less-or-equal, 6 signed greater-or-equal, 7 signed less.
- R9: Codes 8 to 15 on cond_i mean: 8 ~(C|Z), 9 C|Z, 10 ~C, 11 C, 12 ~N, 13 N, 14 ~V, 15 V.
- R10: taken_o depends only on cond_i and the registered flags. A flag write in the same cycle has no effect on taken_o until after the next edge.
- R11: Signed greater-or-equal is true when N equals V. Signed greater additionally needs Z clear. Less and less-or-equal are their complements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | DATA_W | ALU result |
| carry_i | input | 1 | ALU carry-out |
| ovf_i | input | 1 | ALU signed overflow |
| op_cls_i | input | 3 | Operation class: 0 add/sub, 1 logical, 2 shift, 3 move, 4 compare, 5-7 reserved |
| flag_we_i | input | 1 | Instruction may write flags |
| cond_i | input | 4 | Branch condition code |
| flags_o | output | 4 | Registered flags {N, Z, V, C} |
| taken_o | output | 1 | Branch condition holds on current flags |

## Verification
The assertions assume that every input is driven to a known value in each cycle once reset is released. They also assume that the reserved class codes are legal and that they simply leave the flags alone. The stimulus changes inputs only on falling edges and never leaves op_cls_i or cond_i undefined. Flag combinations are produced only through the ALU inputs, so the bench never asks for N and Z set together, which a real result cannot produce.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ARITH = 3'd0,
    OP_LOGIC = 3'd1,
    OP_SHIFT = 3'd2,
    OP_MOVE  = 3'd3,
    OP_CMP   = 3'd4
  } op_cls_e;

  typedef enum logic [COND_W-1:0] {
    C_AL = 4'd0,  C_NV = 4'd1,  C_NE = 4'd2,  C_EQ = 4'd3,
    C_GT = 4'd4,  C_LE = 4'd5,  C_GE = 4'd6,  C_LT = 4'd7,
    C_HI = 4'd8,  C_LS = 4'd9,  C_CC = 4'd10, C_CS = 4'd11,
    C_PL = 4'd12, C_MI = 4'd13, C_VC = 4'd14, C_VS = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/ccf_next.sv
module ccf_next
  import ccf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  flags_t             cur_i,
  input  logic [DATA_W-1:0]  res_i,
  input  logic               carry_i,
  input  logic               ovf_i,
  input  logic [OP_W-1:0]    op_cls_i,
  input  logic               we_i,
  output flags_t             nxt_o,
  output logic               load_o
);
  logic res_neg, res_zero;
  logic ld_nz, ld_v, ld_c;

  assign res_neg  = res_i[DATA_W-1];
  assign res_zero = (res_i == '0);

  // per-class write mask
  always_comb begin
    ld_nz = 1'b0;
    ld_v  = 1'b0;
    ld_c  = 1'b0;
    if (we_i) begin
      unique case (op_cls_i)
        OP_ARITH, OP_CMP: begin ld_nz = 1'b1; ld_v = 1'b1; ld_c = 1'b1; end
        OP_LOGIC:         ld_nz = 1'b1;
        OP_SHIFT:         ld_c  = 1'b1;
        default:          ;
      endcase
    end
  end

  always_comb begin
    nxt_o   = cur_i;
    if (ld_nz) begin
      nxt_o.n = res_neg;
      nxt_o.z = res_zero;
    end
    if (ld_v) nxt_o.v = ovf_i;
    if (ld_c) nxt_o.c = carry_i;
  end

  assign load_o = ld_nz | ld_v | ld_c;
endmodule

// File: rtl/ccf_cond.sv
module ccf_cond
  import ccf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  flags_t            flg_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              taken_o
);
  localparam int unsigned PAIRS = 1 << (COND_W - 1);

  logic [PAIRS-1:0] base;
  logic             sge;

  assign sge = (flg_i.n == flg_i.v);

  // each odd code is the complement of the even code below it
  always_comb begin
    base[0] = 1'b1;
    base[1] = ~flg_i.z;
    base[2] = sge & ~flg_i.z;
    base[3] = sge;
    base[4] = ~(flg_i.c | flg_i.z);
    base[5] = ~flg_i.c;
    base[6] = ~flg_i.n;
    base[7] = ~flg_i.v;
  end

  assign taken_o = base[cond_i[COND_W-1:1]] ^ cond_i[0];

  // R8
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_AL) |-> taken_o);
  // R8
  never_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_NV) |-> !taken_o);
  // R11
  ge_nv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_GE) |-> (taken_o == (flg_i.n == flg_i.v)));
  // R11
  gt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == C_GT && flg_i.z) |-> !taken_o);
endmodule

// File: rtl/cc_flag_unit.sv
module cc_flag_unit
  import ccf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic [2:0]        op_cls_i,
  input  logic              flag_we_i,
  input  logic [3:0]        cond_i,
  output logic [3:0]        flags_o,
  output logic              taken_o
);
  flags_t flags_q, flags_d;
  logic   load;

  ccf_next #(.DATA_W(DATA_W)) i_next (
    .cur_i   (flags_q),
    .res_i   (res_i),
    .carry_i (carry_i),
    .ovf_i   (ovf_i),
    .op_cls_i(op_cls_i),
    .we_i    (flag_we_i),
    .nxt_o   (flags_d),
    .load_o  (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (load) flags_q <= flags_d;
  end

  // branch sees registered flags only
  ccf_cond i_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flg_i  (flags_q),
    .cond_i (cond_i),
    .taken_o(taken_o)
  );

  assign flags_o = flags_q;

  // R7
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> (flags_o == $past(flags_o)));
  // R5
  shift_keep_nzv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_cls_i == OP_SHIFT) |=> (flags_o[3:1] == $past(flags_o[3:1])));
  // R4
  logic_keep_vc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_cls_i == OP_LOGIC) |=> (flags_o[1:0] == $past(flags_o[1:0])));
  // R6
  move_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_cls_i == OP_MOVE || op_cls_i > OP_CMP) |=> (flags_o == $past(flags_o)));
  // R2
  arith_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_cls_i == OP_ARITH) |=> (flags_o[2] == ($past(res_i) == '0)));
  // R3
  cmp_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_cls_i == OP_CMP) |=> (flags_o[0] == $past(carry_i)));
endmodule

// File: tb/test_cc_flag_unit.sv
module test_cc_flag_unit;
  localparam int DW = 32;
  localparam int NV = 12;
  // {op[2:0], we, res[31:0], carry, ovf, exp_nzvc[3:0]}
  localparam logic [41:0] VECS [NV] = '{
    {3'd0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 4'b0101},  // R2
    {3'd1, 1'b1, 32'h8000_0000, 1'b0, 1'b1, 4'b1001},  // R4
    {3'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 4'b1001},  // R7
    {3'd2, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 4'b1000},  // R5
    {3'd4, 1'b1, 32'h0000_1234, 1'b0, 1'b1, 4'b0010},  // R3
    {3'd3, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 4'b0010},  // R6
    {3'd5, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 4'b0010},  // R6
    {3'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b0011},  // R5
    {3'd1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'b0111},  // R4
    {3'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'b1000},  // R2
    {3'd4, 1'b1, 32'h7FFF_FFFF, 1'b1, 1'b1, 4'b0011},  // R3
    {3'd2, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 4'b0011}   // R7
  };
  localparam string VTAG [NV] = '{"R2","R4","R7","R5","R3","R6","R6","R5","R4","R2","R3","R7"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] res = '0;
  logic          carry = 1'b0, ovf = 1'b0, we = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [3:0]    cond = 4'd0;
  logic [3:0]    flags;
  logic          taken;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  cc_flag_unit #(.DATA_W(DW)) i_cc_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .carry_i(carry), .ovf_i(ovf),
    .op_cls_i(op), .flag_we_i(we), .cond_i(cond), .flags_o(flags), .taken_o(taken)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model(logic [3:0] f, int c);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      0: return 1'b1;             1: return 1'b0;
      2: return !z;               3: return z;
      4: return (n == v) && !z;   5: return (n != v) || z;
      6: return n == v;           7: return n != v;
      8: return !(cy || z);       9: return cy || z;
      10: return !cy;             11: return cy;
      12: return !n;              13: return n;
      14: return !v;              default: return v;
    endcase
  endfunction

  function automatic string ctag(int c);
    if (c >= 4 && c <= 7) return "R11";
    return (c < 8) ? "R8" : "R9";
  endfunction

  initial begin
    #8;
    check("R1", flags, 4'b0000);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {op, we, res, carry, ovf} = VECS[i][41:4];
      @(negedge clk);
      check(VTAG[i], flags, VECS[i][3:0]);
    end
    we = 1'b0;

    // all reachable flag sets, every condition
    for (int f = 0; f < 16; f++) begin
      if (f[3] && f[2]) continue;
      op = 3'd0; we = 1'b1;
      res = f[2] ? 32'h0 : (f[3] ? 32'h8000_0001 : 32'h0000_0001);
      ovf = f[1]; carry = f[0];
      @(negedge clk);
      we = 1'b0;
      for (int c = 0; c < 16; c++) begin
        cond = c[3:0];
        #1;
        check(ctag(c), taken, model(f[3:0], c));
      end
    end

    // R10: same-cycle write does not reach taken_o before the edge
    op = 3'd0; we = 1'b1; res = 32'h5; carry = 1'b0; ovf = 1'b0;
    @(negedge clk);
    res = 32'h0; cond = 4'd3;
    #1;
    check("R10", taken, 1'b0);
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R10", taken, 1'b1);

    // R10: decrement to positive then branch-if-positive next cycle
    we = 1'b1; res = 32'hFFFF_FFFF; cond = 4'd12;
    @(negedge clk);
    res = 32'h0000_0003;
    #1;
    check("R10", taken, 1'b0);
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R10", taken, 1'b1);

    // R1: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R1", flags, 4'b0000);
    cond = 4'd0;
    #1;
    check("R1", taken, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule